// File: doc/BRIEF.md
# Exception and Interrupt Prioritiser

This block decides, once per clock, whether the processor must leave its normal instruction stream and where it must go. It weighs three classes of event against each other: the reset line, the level-sensitive interrupt requests (each gated by its own mask bit and by one global enable) and the synchronous faults that the pipeline reports for the instruction it is about to retire. The fixed ordering puts reset first, every interrupt second and every synchronous fault last. Within each tier a fixed order also applies.

For the winning event the block registers a redirect strobe, the vector address, the cause code, and the value to save as the exception PC. It also registers a strobe to capture the faulting data address and a strobe that tells the status register to push its mode and interrupt-enable stack. While reset is held, the outputs show the reset vector and a kernel-mode, interrupts-off initialisation strobe. The surrounding pipeline uses the redirect to fetch from the new vector and writes the cause and exception PC into its control registers.

Top module: `exc_prioritiser`

## Requirements
- R1: While rst_n is low (asynchronous), redir_vld=1, redir_pc=0x0000_1000, kern_init=1, stk_push=0 and badva_we=0. After release, kern_init stays 0.
- R2: Any taken interrupt wins over every synchronous fault presented in the same cycle. The code is the interrupt's, and epc_val is next_pc.
- R3: Every redirect other than reset targets 0x0000_1100.
- R4: An interrupt line is taken only when its irq_pend bit, its irq_mask bit and irq_gie are all 1. Only bits 6 and 7 are interrupt lines; the other pend and mask bits have no effect.
- R5: Host interrupt (bit 6, code 0) wins over timer interrupt (bit 7, code 2).
- R6: Synchronous faults, qualified by insn_vld, are ranked from highest to lowest as follows: misaligned fetch (code 6), flt_rsvd (10), flt_sys (8), flt_brk (9), flt_ovf (12), flt_ld (4), flt_st (5).
- R7: With insn_vld=1, an insn_pc whose two low bits are not 00 raises the fetch fault (code 6), even with no fault flag set.
- R8: For a synchronous fault, epc_val equals insn_pc. For an interrupt, epc_val equals next_pc.
- R9: badva_we is 1 only when the winner is code 4 or 5, and badva_val then equals fault_addr.
- R10: stk_push is 1 in exactly the cycles in which redir_vld reports a taken (non-reset) event. With no qualified event, both are 0.
- R11: With insn_vld=0, fault flags and a misaligned insn_pc have no effect.
- R12: All results appear at the outputs one clock edge after the inputs that cause them are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | 8 | Pending interrupt bits (6 host, 7 timer) |
| irq_mask | input | 8 | Interrupt mask bits, same positions |
| irq_gie | input | 1 | Global interrupt enable |
| insn_vld | input | 1 | Instruction at the retire point is valid |
| insn_pc | input | 32 | Address of that instruction |
| next_pc | input | 32 | Address of the next unexecuted instruction |
| flt_rsvd | input | 1 | Reserved-instruction fault |
| flt_sys | input | 1 | System-call fault |
| flt_brk | input | 1 | Breakpoint fault |
| flt_ovf | input | 1 | Arithmetic overflow fault |
| flt_ld | input | 1 | Load address fault |
| flt_st | input | 1 | Store address fault |
| fault_addr | input | 32 | Faulting data address |
| redir_vld | output | 1 | Redirect to redir_pc |
| redir_pc | output | 32 | Vector address |
| exc_code | output | 5 | Cause code of the winner |
| epc_val | output | 32 | Value for the exception PC |
| badva_we | output | 1 | Capture strobe for bad address |
| badva_val | output | 32 | Bad address value |
| stk_push | output | 1 | Push mode/enable stack and write cause |
| kern_init | output | 1 | Reset initialisation of mode and enable |

## Verification
All non-reset results come from a single register stage. The code, vector, exception PC, capture strobes and push strobe are therefore due one rising edge after the inputs are applied. The bench drives on the falling edge and compares on the next falling edge, one full edge later, so the result is read in the middle of its valid cycle. It also confirms that the outputs have not yet moved before that edge. The reset outputs are asynchronous and are sampled shortly after rst_n falls, with no clock edge in between.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

  localparam logic [4:0] CODE_HOST  = 5'd0;
  localparam logic [4:0] CODE_TIMER = 5'd2;
  localparam logic [4:0] CODE_LDADR = 5'd4;
  localparam logic [4:0] CODE_STADR = 5'd5;
  localparam logic [4:0] CODE_FETCH = 5'd6;
  localparam logic [4:0] CODE_SYS   = 5'd8;
  localparam logic [4:0] CODE_BRK   = 5'd9;
  localparam logic [4:0] CODE_RSVD  = 5'd10;
  localparam logic [4:0] CODE_OVF   = 5'd12;

  typedef struct packed {
    logic       hit;
    logic [4:0] code;
  } pick_t;

  // fault flag vector order: {rsvd, sys, brk, ovf, ld, st}
  typedef struct packed {
    logic rsvd;
    logic sys;
    logic brk;
    logic ovf;
    logic ld;
    logic st;
  } flt_t;

  // Interrupt tier: host line before timer line.
  function automatic pick_t irq_pick(input logic host_on, input logic timer_on);
    pick_t r;
    r.hit  = host_on | timer_on;
    r.code = host_on ? CODE_HOST : (timer_on ? CODE_TIMER : 5'd0);
    return r;
  endfunction

  // Synchronous tier: fixed rank, fetch misalignment first.
  function automatic pick_t flt_pick(input logic misal, input flt_t f);
    pick_t r;
    r.hit = 1'b1;
    if (misal)      r.code = CODE_FETCH;
    else if (f.rsvd) r.code = CODE_RSVD;
    else if (f.sys)  r.code = CODE_SYS;
    else if (f.brk)  r.code = CODE_BRK;
    else if (f.ovf)  r.code = CODE_OVF;
    else if (f.ld)   r.code = CODE_LDADR;
    else if (f.st)   r.code = CODE_STADR;
    else begin
      r.hit  = 1'b0;
      r.code = 5'd0;
    end
    return r;
  endfunction

endpackage

// File: rtl/exc_irq_sel.sv
module exc_irq_sel #(
  parameter int IRQ_W     = 8,
  parameter int HOST_IDX  = 6,
  parameter int TIMER_IDX = 7
) (
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] mask,
  input  logic             gie,
  output logic             hit,
  output logic [4:0]       code
);
  import exc_prio_pkg::*;

  logic [IRQ_W-1:0] live;
  pick_t            pk;

  assign live = pend & mask & {IRQ_W{gie}};
  assign pk   = irq_pick(live[HOST_IDX], live[TIMER_IDX]);
  assign hit  = pk.hit;
  assign code = pk.code;
endmodule

// File: rtl/exc_flt_sel.sv
module exc_flt_sel #(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic            vld,
  input  logic [XLEN-1:0] pc,
  input  exc_prio_pkg::flt_t flags,
  output logic            hit,
  output logic [4:0]      code
);
  import exc_prio_pkg::*;

  logic  misal;
  flt_t  qual;
  pick_t pk;

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign misal = vld & (|pc[ALIGN_BITS-1:0]);
    end else begin : g_noalign
      assign misal = 1'b0;
    end
  endgenerate

  assign qual = vld ? flags : '0;
  assign pk   = flt_pick(misal, qual);
  assign hit  = pk.hit;
  assign code = pk.code;
endmodule

// File: rtl/exc_prioritiser.sv
module exc_prioritiser #(
  parameter int          XLEN      = 32,
  parameter int          IRQ_W     = 8,
  parameter int          HOST_IDX  = 6,
  parameter int          TIMER_IDX = 7,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter logic [31:0] TRAP_VEC  = 32'h0000_1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_mask,
  input  logic             irq_gie,
  input  logic             insn_vld,
  input  logic [XLEN-1:0]  insn_pc,
  input  logic [XLEN-1:0]  next_pc,
  input  logic             flt_rsvd,
  input  logic             flt_sys,
  input  logic             flt_brk,
  input  logic             flt_ovf,
  input  logic             flt_ld,
  input  logic             flt_st,
  input  logic [XLEN-1:0]  fault_addr,
  output logic             redir_vld,
  output logic [XLEN-1:0]  redir_pc,
  output logic [4:0]       exc_code,
  output logic [XLEN-1:0]  epc_val,
  output logic             badva_we,
  output logic [XLEN-1:0]  badva_val,
  output logic             stk_push,
  output logic             kern_init
);
  import exc_prio_pkg::*;

  localparam logic [XLEN-1:0] RST_PC  = XLEN'(RESET_VEC);
  localparam logic [XLEN-1:0] TRAP_PC = XLEN'(TRAP_VEC);

  flt_t       flags;
  logic       irq_hit, flt_hit, take, ldst_win;
  logic [4:0] irq_code, flt_code, win_code;

  assign flags = '{rsvd: flt_rsvd, sys: flt_sys, brk: flt_brk,
                   ovf: flt_ovf, ld: flt_ld, st: flt_st};

  exc_irq_sel #(.IRQ_W(IRQ_W), .HOST_IDX(HOST_IDX), .TIMER_IDX(TIMER_IDX)) u_irq (
    .pend(irq_pend), .mask(irq_mask), .gie(irq_gie),
    .hit(irq_hit), .code(irq_code)
  );

  exc_flt_sel #(.XLEN(XLEN), .ALIGN_BITS(2)) u_flt (
    .vld(insn_vld), .pc(insn_pc), .flags(flags),
    .hit(flt_hit), .code(flt_code)
  );

  // Tier arbitration: interrupts always ahead of synchronous faults.
  assign take     = irq_hit | flt_hit;
  assign win_code = irq_hit ? irq_code : flt_code;
  assign ldst_win = !irq_hit && flt_hit &&
                    (flt_code == CODE_LDADR || flt_code == CODE_STADR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_vld <= 1'b1;
      redir_pc  <= RST_PC;
      exc_code  <= 5'd0;
      epc_val   <= '0;
      badva_we  <= 1'b0;
      badva_val <= '0;
      stk_push  <= 1'b0;
      kern_init <= 1'b1;
    end else begin
      kern_init <= 1'b0;
      redir_vld <= take;
      stk_push  <= take;
      redir_pc  <= TRAP_PC;
      exc_code  <= take ? win_code : 5'd0;
      epc_val   <= irq_hit ? next_pc : insn_pc;
      badva_we  <= ldst_win;
      badva_val <= fault_addr;
    end
  end

  // R2: interrupt tier beats a simultaneous fault
  p_irq_over_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hit && flt_hit) |=> (redir_vld && (exc_code == CODE_HOST || exc_code == CODE_TIMER)));

  // R3: every non-reset redirect uses the common vector
  p_common_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && !kern_init) |-> (redir_pc == TRAP_PC));

  // R8: fault-only cycle saves the faulting instruction address
  p_epc_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_hit && !irq_hit) |=> (epc_val == $past(insn_pc)));

  // R9: bad-address capture only for load/store address faults
  p_badva_ldst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    badva_we |-> (exc_code == CODE_LDADR || exc_code == CODE_STADR));

  // R10: no qualified event, no redirect and no push
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_hit && !flt_hit) |=> (!redir_vld && !stk_push));

  // R10: push only together with a redirect
  p_push_redir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |-> (redir_vld && !kern_init));

endmodule

// File: tb/test_exc_prioritiser.sv
`timescale 1ns/1ps
module test_exc_prioritiser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pend = '0, irq_mask = '0;
  logic        irq_gie = 1'b0, insn_vld = 1'b0;
  logic [31:0] insn_pc = 32'h0000_4000, next_pc = 32'h0000_4004;
  logic        flt_rsvd = 0, flt_sys = 0, flt_brk = 0, flt_ovf = 0, flt_ld = 0, flt_st = 0;
  logic [31:0] fault_addr = 32'hDEAD_BEE0;
  logic        redir_vld, badva_we, stk_push, kern_init;
  logic [31:0] redir_pc, epc_val, badva_val;
  logic [4:0]  exc_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_prioritiser i_exc_prioritiser (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .irq_gie(irq_gie), .insn_vld(insn_vld), .insn_pc(insn_pc), .next_pc(next_pc),
    .flt_rsvd(flt_rsvd), .flt_sys(flt_sys), .flt_brk(flt_brk), .flt_ovf(flt_ovf),
    .flt_ld(flt_ld), .flt_st(flt_st), .fault_addr(fault_addr),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .exc_code(exc_code), .epc_val(epc_val),
    .badva_we(badva_we), .badva_val(badva_val), .stk_push(stk_push), .kern_init(kern_init)
  );

  typedef struct packed {
    logic [1:0] pend;   // {timer bit7, host bit6}
    logic [1:0] mask;
    logic       gie;
    logic       vld;
    logic [1:0] pclo;
    logic [5:0] flt;    // {rsvd, sys, brk, ovf, ld, st}
    logic       ev;
    logic [4:0] code;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b000000, 1'b0, 5'd0},   // R10 idle
    '{2'b01, 2'b01, 1'b1, 1'b0, 2'd0, 6'b000000, 1'b1, 5'd0},   // R4 host
    '{2'b10, 2'b10, 1'b1, 1'b0, 2'd0, 6'b000000, 1'b1, 5'd2},   // R4 timer
    '{2'b11, 2'b11, 1'b1, 1'b0, 2'd0, 6'b000000, 1'b1, 5'd0},   // R5 both
    '{2'b11, 2'b10, 1'b1, 1'b0, 2'd0, 6'b000000, 1'b1, 5'd2},   // R4 host masked
    '{2'b11, 2'b11, 1'b0, 1'b0, 2'd0, 6'b000000, 1'b0, 5'd0},   // R4 gie off
    '{2'b01, 2'b10, 1'b1, 1'b0, 2'd0, 6'b000000, 1'b0, 5'd0},   // R4 pend/mask mismatch
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd2, 6'b111111, 1'b1, 5'd6},   // R7 misaligned
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b111111, 1'b1, 5'd10},  // R6
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b011111, 1'b1, 5'd8},   // R6
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b001111, 1'b1, 5'd9},   // R6
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b000111, 1'b1, 5'd12},  // R6
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b000011, 1'b1, 5'd4},   // R6 R9
    '{2'b00, 2'b00, 1'b0, 1'b1, 2'd0, 6'b000001, 1'b1, 5'd5},   // R6 R9
    '{2'b00, 2'b00, 1'b0, 1'b0, 2'd1, 6'b111111, 1'b0, 5'd0},   // R11
    '{2'b01, 2'b01, 1'b1, 1'b1, 2'd1, 6'b111111, 1'b1, 5'd0},   // R2
    '{2'b11, 2'b11, 1'b0, 1'b1, 2'd0, 6'b000010, 1'b1, 5'd4}    // R4 R9
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    irq_pend = '0; irq_mask = '0;
    irq_pend[6] = v.pend[0]; irq_pend[7] = v.pend[1];
    irq_mask[6] = v.mask[0]; irq_mask[7] = v.mask[1];
    irq_gie  = v.gie;
    insn_vld = v.vld;
    insn_pc  = 32'h0000_4000 | {30'd0, v.pclo};
    {flt_rsvd, flt_sys, flt_brk, flt_ovf, flt_ld, flt_st} = v.flt;
  endtask

  function automatic bit is_irq(input logic [4:0] c);
    return c == 5'd0 || c == 5'd2;
  endfunction

  initial begin
    #7;
    // R1: reset state
    chk("R1 vld", {31'd0, redir_vld}, 32'd1);
    chk("R1 pc", redir_pc, 32'h0000_1000);
    chk("R1 kinit", {31'd0, kern_init}, 32'd1);
    chk("R1 push", {31'd0, stk_push}, 32'd0);
    chk("R1 badva", {31'd0, badva_we}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 kinit low", {31'd0, kern_init}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      @(negedge clk);
      chk($sformatf("R10 vld v%0d", i), {31'd0, redir_vld}, {31'd0, TBL[i].ev});
      chk($sformatf("R10 push v%0d", i), {31'd0, stk_push}, {31'd0, TBL[i].ev});
      if (TBL[i].ev) begin
        chk($sformatf("R6 code v%0d", i), {27'd0, exc_code}, {27'd0, TBL[i].code});
        chk($sformatf("R3 pc v%0d", i), redir_pc, 32'h0000_1100);
        chk($sformatf("R8 epc v%0d", i), epc_val,
            is_irq(TBL[i].code) ? next_pc : (32'h0000_4000 | {30'd0, TBL[i].pclo}));
        chk($sformatf("R9 bvwe v%0d", i), {31'd0, badva_we},
            {31'd0, (TBL[i].code == 5'd4 || TBL[i].code == 5'd5)});
        if (TBL[i].code == 5'd4 || TBL[i].code == 5'd5)
          chk($sformatf("R9 bva v%0d", i), badva_val, fault_addr);
      end
    end

    // R4: non-interrupt bit positions ignored
    @(negedge clk);
    apply('0); irq_pend = 8'h3F; irq_mask = 8'h3F; irq_gie = 1'b1;
    @(negedge clk);
    chk("R4 other bits", {31'd0, redir_vld}, 32'd0);

    // R12: result not visible before the edge, visible after
    apply('0); irq_pend = 8'h80; irq_mask = 8'h80; irq_gie = 1'b1;
    #1;
    chk("R12 before edge", {31'd0, redir_vld}, 32'd0);
    @(negedge clk);
    chk("R12 after edge", {27'd0, exc_code}, 32'd2);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk("R1 async pc", redir_pc, 32'h0000_1000);
    chk("R1 async kinit", {31'd0, kern_init}, 32'd1);
    chk("R1 async push", {31'd0, stk_push}, 32'd0);
    @(negedge clk); rst_n = 1'b1; apply('0);
    @(negedge clk);
    chk("R10 idle after reset", {31'd0, redir_vld}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule